// File: doc/BRIEF.md
# Dual-Output Configurable Logic Cell

This block is a single programmable logic cell. It combines a lookup-table function generator, two flip-flops and a set of output multiplexers. Five logic variables and a direct data bit come in, and two outputs, X and Y, go out. All personalisation comes from one static configuration vector that is held constant while the cell runs. One mode bit sets how the table storage is used. In wide mode it acts as one truth table over all five inputs, and the same result appears on both function outputs F and G. In split mode it acts as two independent four-input tables. Each of their inputs is chosen from the five variables, the two flip-flop outputs or a constant zero, so the cell can build small state machines without outside wiring.

Each flip-flop loads F, G or the direct data bit on a rising clock edge when the clock enable is high. An asynchronous active-high reset clears both flip-flops. Each output chooses between its function output and its flip-flop. The number of logic variables is a parameter. The table size, the select-code width and the configuration layout all follow from it.

Top module: `clb_cell`

## Requirements
- R1: When cfg[0]=1 (wide mode), F and G both equal table bit cfg[1+v]. Here v is the value of lin with lin[0] as its LSB and lin[4] (input E) as its MSB, so E picks the upper or lower 16-entry half. The F/G select fields have no effect in this mode.
- R2: When cfg[0]=0 (split mode), F equals cfg[1+i] and G equals cfg[17+i'], with i and i' each 0..15. Bit j of i comes from the source named by the 3-bit F select field cfg[33+3j +: 3]. Bit j of i' comes from the G select field cfg[45+3j +: 3].
- R3: Select codes 0..4 take lin[0]..lin[4], code 5 takes the Q1 flip-flop output, code 6 takes Q2, and code 7 gives constant 0.
- R4: On a rising clk edge with ce=1, Q1 loads the source named by cfg[58:57] and Q2 loads the source named by cfg[60:59]. Code 0 selects F, code 1 selects G, and codes 2 and 3 select din.
- R5: While ce=0, rising clk edges leave Q1 and Q2 unchanged, whatever lin and din do.
- R6: glb_rst=1 clears Q1 and Q2 to 0 at once, without waiting for a clock edge and whatever the value of ce.
- R7: x_out shows F when cfg[61]=0 and Q1 when cfg[61]=1. y_out shows G when cfg[62]=0 and Q2 when cfg[62]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| glb_rst | input | 1 | Asynchronous reset of both flip-flops, active high |
| ce | input | 1 | Clock enable shared by both flip-flops |
| din | input | 1 | Direct data input for the flip-flops |
| lin | input | N_IN (5) | Logic variables, lin[0]=A through lin[4]=E |
| cfg | input | CFG_W (63) | Static configuration vector |
| x_out | output | 1 | Output X: F or Q1 |
| y_out | output | 1 | Output Y: G or Q2 |

## Verification
The bench builds the cell with the default N_IN=5. This gives a 32-bit table, 3-bit select codes and a 63-bit configuration vector, so all 32 input values in each mode can be swept in full. With 3-bit select codes, all eight codes can be reached, including the two feedback codes and the constant-zero code. A feedback sequence checks a two-flip-flop state machine against a model cycle by cycle. Further scenarios cover the alternate din code, the hold behaviour and reset asserted between clock edges.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;
   // flip-flop data source codes
   typedef enum logic [1:0] {
      DSRC_F    = 2'd0,
      DSRC_G    = 2'd1,
      DSRC_DIN  = 2'd2,
      DSRC_DIN2 = 2'd3
   } dsrc_e;
endpackage

// File: rtl/clb_in_sel.sv
`timescale 1ns/1ps
// Picks K table-index bits out of a candidate pool; codes beyond the pool read 0.
module clb_in_sel #(
   parameter int POOL  = 7,
   parameter int SEL_W = 3,
   parameter int K     = 4
) (
   input  logic [POOL-1:0]    pool,
   input  logic [K*SEL_W-1:0] sel,
   output logic [K-1:0]       idx
);
   localparam int EXT = 1 << SEL_W;

   if (EXT <= POOL) begin : g_bad_width
      $error("clb_in_sel: SEL_W too narrow for a constant-zero code");
   end

   logic [EXT-1:0] pool_ext;
   assign pool_ext = {{(EXT-POOL){1'b0}}, pool};

   for (genvar j = 0; j < K; j++) begin : g_bit
      assign idx[j] = pool_ext[sel[j*SEL_W +: SEL_W]];
   end
endmodule

// File: rtl/clb_func_gen.sv
`timescale 1ns/1ps
// Lookup-table function generator: one wide table or two split tables.
module clb_func_gen #(
   parameter int N_IN  = 5,
   parameter int SEL_W = 3
) (
   input  logic [N_IN-1:0]            lin,
   input  logic                       q1,
   input  logic                       q2,
   input  logic                       wide,
   input  logic [(1<<N_IN)-1:0]       tbl,
   input  logic [(N_IN-1)*SEL_W-1:0]  fsel,
   input  logic [(N_IN-1)*SEL_W-1:0]  gsel,
   output logic                       f,
   output logic                       g
);
   localparam int K    = N_IN - 1;
   localparam int POOL = N_IN + 2;

   logic [POOL-1:0] pool;
   logic [K-1:0]    fidx, gidx;
   logic [N_IN-1:0] ia, ib;

   assign pool = {q2, q1, lin};

   clb_in_sel #(.POOL(POOL), .SEL_W(SEL_W), .K(K)) u_fsel (
      .pool(pool), .sel(fsel), .idx(fidx)
   );
   clb_in_sel #(.POOL(POOL), .SEL_W(SEL_W), .K(K)) u_gsel (
      .pool(pool), .sel(gsel), .idx(gidx)
   );

   always_comb begin
      if (wide) begin
         ia = lin;             // MSB (E) picks the table half
         ib = lin;
      end else begin
         ia = {1'b0, fidx};    // lower half holds F
         ib = {1'b1, gidx};    // upper half holds G
      end
   end

   assign f = tbl[ia];
   assign g = tbl[ib];
endmodule

// File: rtl/clb_store.sv
`timescale 1ns/1ps
// One cell flip-flop with its data-source multiplexer.
module clb_store
   import clb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       ce,
   input  logic [1:0] src,
   input  logic       f,
   input  logic       g,
   input  logic       din,
   output logic       q
);
   logic d;

   always_comb begin
      case (dsrc_e'(src))
         DSRC_F:  d = f;
         DSRC_G:  d = g;
         default: d = din;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     q <= 1'b0;
      else if (ce) q <= d;
   end

   // R5: disabled clock enable holds the stored value
   a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
      !ce |=> q == $past(q));

   // R4: din source codes load the direct input
   a_r4_din_load: assert property (@(posedge clk) disable iff (rst)
      (ce && src[1]) |=> q == $past(din));

   // R4: code 0 loads the F function output
   a_r4_f_load: assert property (@(posedge clk) disable iff (rst)
      (ce && src == 2'd0) |=> q == $past(f));
endmodule

// File: rtl/clb_cell.sv
`timescale 1ns/1ps
// Configurable logic cell: function generator, two flip-flops, output muxes.
module clb_cell #(
   parameter int  N_IN     = 5,
   localparam int K        = N_IN - 1,
   localparam int SEL_W    = $clog2(N_IN + 3),
   localparam int TBL_N    = 1 << N_IN,
   localparam int OFF_TBL  = 1,
   localparam int OFF_FSEL = OFF_TBL + TBL_N,
   localparam int OFF_GSEL = OFF_FSEL + K*SEL_W,
   localparam int OFF_SRC  = OFF_GSEL + K*SEL_W,
   localparam int OFF_OSEL = OFF_SRC + 4,
   localparam int CFG_W    = OFF_OSEL + 2
) (
   input  logic             clk,
   input  logic             glb_rst,
   input  logic             ce,
   input  logic             din,
   input  logic [N_IN-1:0]  lin,
   input  logic [CFG_W-1:0] cfg,
   output logic             x_out,
   output logic             y_out
);
   if (N_IN < 2 || N_IN > 8) begin : g_bad_nin
      $error("clb_cell: N_IN must lie in 2..8");
   end

   logic             f, g;
   logic [1:0]       q, comb, outv;
   logic [TBL_N-1:0] tbl_w;

   assign tbl_w = cfg[OFF_TBL +: TBL_N];

   clb_func_gen #(.N_IN(N_IN), .SEL_W(SEL_W)) u_fgen (
      .lin  (lin),
      .q1   (q[0]),
      .q2   (q[1]),
      .wide (cfg[0]),
      .tbl  (tbl_w),
      .fsel (cfg[OFF_FSEL +: K*SEL_W]),
      .gsel (cfg[OFF_GSEL +: K*SEL_W]),
      .f    (f),
      .g    (g)
   );

   assign comb = {g, f};

   for (genvar i = 0; i < 2; i++) begin : g_ff
      clb_store u_ff (
         .clk (clk),
         .rst (glb_rst),
         .ce  (ce),
         .src (cfg[OFF_SRC + 2*i +: 2]),
         .f   (f),
         .g   (g),
         .din (din),
         .q   (q[i])
      );
      assign outv[i] = cfg[OFF_OSEL + i] ? q[i] : comb[i];
   end

   assign x_out = outv[0];
   assign y_out = outv[1];

   // R1: wide mode reads the full table on both combinational outputs
   a_r1_wide_table: assert property (@(posedge clk) disable iff (glb_rst)
      (cfg[0] && !cfg[OFF_OSEL] && !cfg[OFF_OSEL+1])
         |-> (x_out == tbl_w[lin] && y_out == x_out));

   // R7: registered X shows what Q1 captured from G
   a_r7_x_reg_from_g: assert property (@(posedge clk) disable iff (glb_rst)
      (cfg[OFF_OSEL] && ce && cfg[OFF_SRC +: 2] == 2'd1) |=> x_out == $past(g));

   // R7: registered Y shows what Q2 captured from din
   a_r7_y_reg_from_din: assert property (@(posedge clk) disable iff (glb_rst)
      (cfg[OFF_OSEL+1] && ce && cfg[OFF_SRC+3]) |=> y_out == $past(din));
endmodule

// File: tb/tb_clb_cell.sv
`timescale 1ns/1ps
module tb_clb_cell;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce  = 1'b0;
   logic        din = 1'b0;
   logic [4:0]  lin = '0;
   logic [62:0] cfg = '0;
   logic        x_out, y_out;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic        q1m, q2m;

   always #4 clk = ~clk;   // 125 MHz

   clb_cell dut (
      .clk(clk), .glb_rst(rst), .ce(ce), .din(din), .lin(lin),
      .cfg(cfg), .x_out(x_out), .y_out(y_out)
   );

   function automatic logic [11:0] sels(input logic [2:0] c3, c2, c1, c0);
      return {c3, c2, c1, c0};
   endfunction

   function automatic logic [62:0] mk(input logic wide, input logic [31:0] tbl,
                                      input logic [11:0] fs, gs,
                                      input logic [1:0] s1, s2,
                                      input logic xr, yr);
      logic [62:0] c;
      c = '0;
      c[0]     = wide;
      c[32:1]  = tbl;
      c[44:33] = fs;
      c[56:45] = gs;
      c[58:57] = s1;
      c[60:59] = s2;
      c[61]    = xr;
      c[62]    = yr;
      return c;
   endfunction

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic t_reset;   // R6
      cfg = mk(1'b0, 32'h0, '0, '0, 2'd2, 2'd2, 1'b1, 1'b1);
      #20;
      chk(x_out, 1'b0, "R6 reset clears Q1");
      chk(y_out, 1'b0, "R6 reset clears Q2");
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_wide;    // R1
      logic [31:0] t;
      t = 32'h9B2E_4C71;
      cfg = mk(1'b1, t, sels(5, 6, 5, 6), sels(7, 7, 7, 7), 2'd0, 2'd0, 1'b0, 1'b0);
      for (int v = 0; v < 32; v++) begin
         lin = v[4:0];
         #1;
         chk(x_out, t[v], "R1 wide F");
         chk(y_out, t[v], "R1 wide G");
      end
   endtask

   task automatic t_split;   // R2, R3
      logic [15:0] tf, tg;
      logic [3:0]  gi;
      tf = 16'hE41B;
      tg = 16'h3A95;
      cfg = mk(1'b0, {tg, tf}, sels(3, 2, 1, 0), sels(2, 7, 0, 4), 2'd0, 2'd0, 1'b0, 1'b0);
      for (int v = 0; v < 32; v++) begin
         logic [4:0] w;
         w = v[4:0];
         lin = w;
         gi = {w[2], 1'b0, w[0], w[4]};
         #1;
         chk(x_out, tf[w[3:0]], "R2 split F");
         chk(y_out, tg[gi], "R3 select codes incl zero");
      end
   endtask

   task automatic t_feedback;   // R3, R4, R7
      logic [11:0] pat;
      logic        n2;
      pat = 12'b1011_0010_1110;
      @(negedge clk);
      cfg = mk(1'b0, {16'h0000, 16'h6666}, sels(7, 7, 6, 5), sels(7, 7, 7, 7),
               2'd2, 2'd0, 1'b0, 1'b1);
      q1m = 1'b0; q2m = 1'b0;
      ce = 1'b1;
      for (int k = 0; k < 12; k++) begin
         din = pat[k];
         @(posedge clk);
         n2 = q1m ^ q2m;
         q1m = din;
         q2m = n2;
         #1;
         chk(y_out, q2m, "R4 Q2 from F with feedback");
         chk(x_out, q1m ^ q2m, "R3 F over Q1/Q2 feedback, R7 comb X");
      end
   endtask

   task automatic t_gsrc;    // R4, R7
      logic [5:0] pa, pd;
      pa = 6'b101101;
      pd = 6'b010110;
      @(negedge clk);
      cfg = mk(1'b0, {16'hAAAA, 16'h0000}, sels(7, 7, 7, 7), sels(7, 7, 7, 0),
               2'd1, 2'd3, 1'b1, 1'b1);
      ce = 1'b1;
      for (int k = 0; k < 6; k++) begin
         lin = {4'b0000, pa[k]};
         din = pd[k];
         @(posedge clk);
         #1;
         chk(x_out, pa[k], "R4 Q1 from G, R7 reg X");
         chk(y_out, pd[k], "R4 Q2 from din code 3, R7 reg Y");
      end
   endtask

   task automatic t_hold;    // R5
      @(negedge clk);
      ce = 1'b0;
      for (int k = 0; k < 4; k++) begin
         lin = {4'b0000, k[0]};
         din = ~k[0];
         @(posedge clk);
         #1;
         chk(x_out, 1'b1, "R5 Q1 holds");
         chk(y_out, 1'b0, "R5 Q2 holds");
      end
   endtask

   task automatic t_async_rst;   // R6
      @(negedge clk);
      ce  = 1'b1;
      lin = 5'b00001;
      din = 1'b1;
      #1;
      rst = 1'b1;
      #1;
      chk(x_out, 1'b0, "R6 async clear Q1 between edges");
      @(posedge clk);
      #1;
      chk(x_out, 1'b0, "R6 reset overrides ce Q1");
      chk(y_out, 1'b0, "R6 reset overrides ce Q2");
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      t_reset();
      t_wide();
      t_split();
      t_feedback();
      t_gsrc();
      t_hold();
      t_async_rst();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1600000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule